// File: doc/BRIEF.md
# Chainable Top-K Nearest Candidate Queue

This block keeps the k smallest-distance candidates seen so far during a nearest-neighbour scan. Every entry is an (id, distance) pair held in a compare-and-shift register cell. One segment is a linear array of 16 such cells. The array is sorted in every cycle, so position 0 always holds the closest candidate found so far.

An insert lands in one cycle. A combinational read port returns the id or the distance stored at any position. A clear command empties the whole segment at once.

Segments chain through cascade ports to give a larger k. The pair pushed out of the last cell of one segment is the insert input of the next segment. An enable input turns a segment off. A disabled segment stores nothing and passes nothing on.

Top module: `topk_queue_seg`

## Requirements
- R1: Stored entries are ordered by ascending distance, with position 0 holding the smallest. Valid entries occupy positions 0 upward with no gaps.
- R2: An inserted distance equal to one or more stored distances is placed after all of those equal entries.
- R3: The read port is combinational. `rd_sel`=1 returns the id at `rd_pos` and `rd_sel`=0 returns the distance. An empty position reads id 0 and distance 0xFFFFFFFF.
- R4: An insert presented while `ins_valid`=1 is visible on the read port after the next rising clock edge.
- R5: On a full segment, an insert that ranks inside the segment pushes the last entry out on the cascade port in the same cycle. An insert whose distance is not smaller than every stored one is itself driven out on the cascade port. Either way, the segment keeps the 16 smallest.
- R6: `clr`=1 empties every cell at the next edge and takes priority over a simultaneous insert.
- R7: With `en`=0 an insert changes no cell and `cas_valid` stays 0.
- R8: Two chained, enabled segments hold the 32 smallest distances in order, with positions 16..31 in the second segment.
- R9: After `rst_n` is held low, every cell is empty, exactly as after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clear all cells |
| en | input | 1 | Segment enable |
| ins_valid | input | 1 | Insert strobe |
| ins_id | input | IDW | Candidate id |
| ins_val | input | VALW | Candidate distance (unsigned) |
| rd_pos | input | log2(DEPTH) | Read position |
| rd_sel | input | 1 | 1 = id, 0 = distance |
| rd_data | output | max(IDW,VALW) | Read result |
| cas_valid | output | 1 | Pair leaving the tail toward the next segment |
| cas_id | output | IDW | Id of the outgoing pair |
| cas_val | output | VALW | Distance of the outgoing pair |

## Verification
The bench aims at the following corner cases:

- **Equal distances.** Repeated distances must land in arrival order. A design that compares with greater-or-equal would put a newer duplicate ahead of an older one.
- **Overflow into a second segment.** The bench drives enough inserts to overflow one segment into a second. A wrong tail choice would lose or duplicate entries at the segment boundary.
- **Full segment, large distance.** The bench checks the cascade output when the arriving distance is larger than everything stored. A design that only forwards the last cell would emit the wrong pair here.
- **Clear against insert.** The bench issues a clear together with an insert. A wrong priority would leave one stray entry.
- **Disabled segment.** The bench inserts into a disabled segment. A design that ignores the enable would change its contents or feed the next segment.

// File: rtl/topk_queue_seg.sv
module topk_queue_seg #(
  parameter int DEPTH = 16,
  parameter int IDW   = 32,
  parameter int VALW  = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int DW   = (IDW > VALW) ? IDW : VALW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            ins_valid,
  input  logic [IDW-1:0]  ins_id,
  input  logic [VALW-1:0] ins_val,
  input  logic [PW-1:0]   rd_pos,
  input  logic            rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic            cas_valid,
  output logic [IDW-1:0]  cas_id,
  output logic [VALW-1:0] cas_val
);

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] gt;
  logic [IDW-1:0]   ids  [DEPTH];
  logic [VALW-1:0]  vals [DEPTH];

  wire go = ins_valid & en & ~clr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign gt[i] = ~vld[i] | (vals[i] > ins_val);

    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          vld[i]  <= 1'b0;
          ids[i]  <= '0;
          vals[i] <= '1;
        end else if (go && gt[i]) begin
          vld[i]  <= 1'b1;
          ids[i]  <= ins_id;
          vals[i] <= ins_val;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          vld[i]  <= 1'b0;
          ids[i]  <= '0;
          vals[i] <= '1;
        end else if (go && gt[i]) begin
          if (!gt[i-1]) begin
            vld[i]  <= 1'b1;
            ids[i]  <= ins_id;
            vals[i] <= ins_val;
          end else begin
            vld[i]  <= vld[i-1];
            ids[i]  <= ids[i-1];
            vals[i] <= vals[i-1];
          end
        end
      end
    end
  end

  wire none_gt = ~|gt;

  assign cas_valid = go & (none_gt | (gt[DEPTH-1] & vld[DEPTH-1]));
  assign cas_id    = none_gt ? ins_id  : ids[DEPTH-1];
  assign cas_val   = none_gt ? ins_val : vals[DEPTH-1];

  assign rd_data = rd_sel ? DW'(ids[rd_pos]) : DW'(vals[rd_pos]);

endmodule

module topk_queue_seg_chk #(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             en,
  input logic             ins_valid,
  input logic             cas_valid,
  input logic [DEPTH-1:0] vld
);

  // R1: valid cells form a contiguous run from position 0
  always_ff @(posedge clk)
    if (rst_n) a_r1_contig: assert (((vld + 1'b1) & vld) == '0);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));

  a_r7_no_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cas_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(vld));

  a_r4_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && en && !clr && !vld[DEPTH-1]) |=>
      ($countones(vld) == $countones($past(vld)) + 1));

  a_r5_spill_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> (ins_valid && en && vld[DEPTH-1]));

endmodule

bind topk_queue_seg topk_queue_seg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
  .ins_valid(ins_valid), .cas_valid(cas_valid), .vld(vld)
);

// File: tb/sim_topk_queue_seg.sv
module sim_topk_queue_seg;
  localparam int CLK_NS = 10;
  localparam int D = 16;

  logic clk = 0, rst_n = 0, clr = 0, en0 = 1, en1 = 1;
  logic ins_valid = 0;
  logic [31:0] ins_id = 0, ins_val = 0;
  logic [3:0] rd_pos0 = 0, rd_pos1 = 0;
  logic rd_sel0 = 0, rd_sel1 = 0;
  logic [31:0] rd_data0, rd_data1;
  logic c0_valid, c1_valid;
  logic [31:0] c0_id, c0_val, c1_id, c1_val;

  always #(CLK_NS/2) clk = ~clk;

  topk_queue_seg u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en0), .ins_valid(ins_valid),
    .ins_id(ins_id), .ins_val(ins_val), .rd_pos(rd_pos0), .rd_sel(rd_sel0),
    .rd_data(rd_data0), .cas_valid(c0_valid), .cas_id(c0_id), .cas_val(c0_val));

  topk_queue_seg u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en1), .ins_valid(c0_valid),
    .ins_id(c0_id), .ins_val(c0_val), .rd_pos(rd_pos1), .rd_sel(rd_sel1),
    .rd_data(rd_data1), .cas_valid(c1_valid), .cas_id(c1_id), .cas_val(c1_val));

  int checks = 0, fails = 0;

  typedef struct {
    int          pos;
    bit          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  logic [31:0] m_id [2*D];
  logic [31:0] m_val[2*D];
  int m_n = 0;
  int cap = 2*D;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at the read ports
  initial forever begin
    item_t it;
    wait (exp_q.size() != 0);
    it = exp_q.pop_front();
    if (it.pos < D) begin
      rd_pos0 = 4'(it.pos); rd_sel0 = it.sel;
      #1 check(it.tag, rd_data0, it.exp);
    end else begin
      rd_pos1 = 4'(it.pos - D); rd_sel1 = it.sel;
      #1 check(it.tag, rd_data1, it.exp);
    end
  end

  task automatic expect_all(string tag);
    for (int p = 0; p < 2*D; p++) begin
      item_t a, b;
      a.pos = p; a.sel = 1; a.tag = tag;
      a.exp = (p < m_n) ? m_id[p] : 32'h0;
      b.pos = p; b.sel = 0; b.tag = tag;
      b.exp = (p < m_n) ? m_val[p] : 32'hFFFF_FFFF;
      exp_q.push_back(a);
      exp_q.push_back(b);
    end
    wait (exp_q.size() == 0);
    #2;
  endtask

  task automatic model_insert(logic [31:0] id, logic [31:0] v);
    int idx = m_n;
    for (int j = m_n - 1; j >= 0; j--)
      if (m_val[j] > v) idx = j;
    if (idx < cap) begin
      for (int j = ((m_n < cap) ? m_n : cap - 1); j > idx; j--) begin
        m_id[j] = m_id[j-1];
        m_val[j] = m_val[j-1];
      end
      m_id[idx] = id;
      m_val[idx] = v;
      if (m_n < cap) m_n++;
    end
  endtask

  task automatic insert(logic [31:0] id, logic [31:0] v);
    @(negedge clk);
    ins_valid = 1; ins_id = id; ins_val = v;
    @(negedge clk);
    ins_valid = 0;
    if (en0) model_insert(id, v);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    m_n = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_all("R9_R3_reset_empty");

    // R1 R4: small out-of-order set, checked right after each edge
    insert(32'd1, 32'd50);
    expect_all("R4_one_insert");
    insert(32'd2, 32'd30);
    insert(32'd3, 32'd70);
    expect_all("R1_R3_order");

    // R2: equal distances keep arrival order
    insert(32'd10, 32'd50);
    insert(32'd11, 32'd50);
    expect_all("R2_ties");

    // R7: disabled head segment ignores insert
    en0 = 0;
    insert(32'd99, 32'd1);
    en0 = 1;
    expect_all("R7_disabled_hold");

    // R6: clear beats simultaneous insert
    @(negedge clk);
    clr = 1; ins_valid = 1; ins_id = 32'd5; ins_val = 32'd5;
    @(negedge clk);
    clr = 0; ins_valid = 0; m_n = 0;
    expect_all("R6_clear_priority");

    // R8 R5: overflow into second segment, with duplicates
    for (int i = 0; i < 45; i++)
      insert(32'd100 + 32'(i), 32'((i * 37 + 11) % 41));
    expect_all("R8_R5_chain32");

    // R7 R5: second segment disabled, head keeps best 16
    clear_all();
    en1 = 0; cap = D;
    for (int i = 0; i < 20; i++)
      insert(32'd200 + 32'(i), 32'((i * 13 + 5) % 29));
    expect_all("R7_R5_seg1_off");

    // R5: larger-than-all distance leaves through cascade in same cycle
    @(negedge clk);
    ins_valid = 1; ins_id = 32'd777; ins_val = 32'd1000;
    #1;
    check("R5_cas_valid_big", {31'd0, c0_valid}, 32'd1);
    check("R5_cas_id_big", c0_id, 32'd777);
    check("R7_seg1_no_cas", {31'd0, c1_valid}, 32'd0);
    @(negedge clk);
    ins_valid = 0;

    // R5: small distance pushes out the old tail
    @(negedge clk);
    ins_valid = 1; ins_id = 32'd888; ins_val = 32'd0;
    #1;
    check("R5_cas_tail_val", c0_val, m_val[D-1]);
    check("R5_cas_tail_id", c0_id, m_id[D-1]);
    @(negedge clk);
    ins_valid = 0;
    model_insert(32'd888, 32'd0);
    expect_all("R5_after_tail_push");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule